// File: doc/BRIEF.md
# Auto-Negotiation Expansion Status Register

This block holds the expansion status word of a 10/100 Ethernet PHY's auto-negotiation logic at management register address 6. The auto-negotiation engine feeds it single-cycle event pulses and level signals:

- a parallel-detection fault pulse, raised when the link partner's technology cannot be resolved;
- a pulse each time a new link codeword has been captured into the partner ability register;
- the level of the next-page bit in the captured partner codeword;
- a pulse when valid fast link pulse bursts are seen from the partner;
- a restart pulse when the link or negotiation restarts.

The block folds these inputs into a 16-bit word that a simple register read port returns.

The bits behave in four different ways:

- Two bits latch high and are cleared by a read of the register: the fault bit and the page-received bit.
- One bit follows the partner's next-page level as it is at the time of the read.
- One bit is wired to one, because the local device can exchange next pages.
- The partner-negotiation-able bit is sticky. Reads do not clear it; only a restart does.

Writes to the register are accepted on the port but change nothing.

Top module: `anx_status_reg`

## Requirements
- R1: While reset is high and on the first cycle after it, `rd_data` is 0x0000. A read of address 6 right after reset returns 0x0004.
- R2: A read strobe (`rd_en`=1) presents the word on `rd_data` in the cycle after the strobe. The word is taken at address 6. A strobe to any other address returns 0x0000 and clears nothing.
- R3: Bit 4 is set by a `pd_fault_pulse` and stays one after the pulse ends, until address 6 is read.
- R4: Bit 1 is set by a `page_stored_pulse` and stays one after the pulse ends, until address 6 is read.
- R5: A read of address 6 returns bits 4 and 1 with their values from before the clear. The bits read zero from the next read onward, unless a new event arrives in between.
- R6: If an event pulse for bit 4 or bit 1 coincides with the read strobe, that read returns the old value and the bit stays set. The next read returns it as one.
- R7: Bit 3 equals the level of `partner_np` in the cycle of the read strobe.
- R8: Bit 2 always reads one and bits 15 to 5 always read zero.
- R9: Bit 0 is set by `flp_valid_pulse` and is not cleared by reads. It is cleared by `an_restart`. When `an_restart` coincides with `flp_valid_pulse`, the restart wins and bit 0 is zero.
- R10: A write strobe (`wr_en`=1) to address 6, with any `wr_data`, leaves every bit of the word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (ignored) |
| addr | input | 5 | Register address |
| wr_data | input | 16 | Write data (ignored) |
| rd_data | output | 16 | Registered read data, valid the cycle after `rd_en` |
| pd_fault_pulse | input | 1 | Parallel-detection fault event |
| page_stored_pulse | input | 1 | New partner codeword stored |
| partner_np | input | 1 | Next-page bit of the stored partner codeword (level) |
| flp_valid_pulse | input | 1 | Valid fast link pulse bursts seen |
| an_restart | input | 1 | Link or negotiation restart |

## Verification
The bench targets four corner cases:

- **Event on the read edge.** A page event lands on the same edge as a read. A design that lets the clear win would drop the event, and the following read would show bit 1 low.
- **Read of another address.** A read strobe goes to address 5 while bits are latched. A block that decodes the strobe without the address would clear them early.
- **Reads and restart on bit 0.** Repeated reads must leave bit 0 set, and a restart that coincides with a new burst must still clear it. A design that treated bit 0 as a latching bit, or gave the burst priority, would read the wrong value.
- **Writes and back-to-back reads.** Writes are interleaved and reads follow one another directly. A write that leaks into the state shows up in the readback. A read that returns the post-clear value loses the fault indication entirely.

// File: rtl/anx_pkg.sv
package anx_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] ANX_ADDR = ADDR_W'(6);

    // bit positions fixed by the management register layout
    localparam int POS_PD_FAULT = 4;
    localparam int POS_LP_NP    = 3;
    localparam int POS_NP_ABLE  = 2;
    localparam int POS_PAGE_RX  = 1;
    localparam int POS_LP_AN    = 0;

    // latching-high sources, indexed for the generate loop
    localparam int NUM_LH    = 2;
    localparam int LH_PDF    = 0;
    localparam int LH_PAGE   = 1;

    typedef struct packed {
        logic pd_fault;
        logic lp_np;
        logic np_able;
        logic page_rx;
        logic lp_an_able;
    } anx_bits_t;

    function automatic logic [REG_W-1:0] anx_pack(anx_bits_t b);
        logic [REG_W-1:0] w;
        w = '0;
        w[POS_PD_FAULT] = b.pd_fault;
        w[POS_LP_NP]    = b.lp_np;
        w[POS_NP_ABLE]  = b.np_able;
        w[POS_PAGE_RX]  = b.page_rx;
        w[POS_LP_AN]    = b.lp_an_able;
        return w;
    endfunction

endpackage

// File: rtl/anx_lh_cell.sv
// One latching-high status bit: set wins over clear-on-read.
module anx_lh_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    assign q_o = q;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);                                  // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o);                     // R5
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(q_o));            // R3
endmodule

// File: rtl/anx_an_able.sv
// Sticky partner-negotiation-able flag; restart has priority over a burst.
module anx_an_able (
    input  logic clk,
    input  logic rst,
    input  logic flp_i,
    input  logic restart_i,
    output logic q_o
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst || restart_i) q <= 1'b0;
        else if (flp_i)       q <= 1'b1;
    end

    assign q_o = q;

    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> !q_o);                             // R9
    AST_BURST_SETS: assert property (@(posedge clk) disable iff (rst)
        (flp_i && !restart_i) |=> q_o);                  // R9
endmodule

// File: rtl/anx_status_reg.sv
module anx_status_reg
    import anx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              pd_fault_pulse,
    input  logic              page_stored_pulse,
    input  logic              partner_np,
    input  logic              flp_valid_pulse,
    input  logic              an_restart
);
    logic              rd_hit;
    logic [NUM_LH-1:0] lh_set;
    logic [NUM_LH-1:0] lh_q;
    logic              an_able;
    anx_bits_t         bits;
    logic [REG_W-1:0]  rd_q;
    logic              wr_unused;

    // the register is read-only: write strobe and data are consumed and dropped
    assign wr_unused = wr_en & (^wr_data);

    assign rd_hit = rd_en && (addr == ANX_ADDR);

    assign lh_set[LH_PDF]  = pd_fault_pulse;
    assign lh_set[LH_PAGE] = page_stored_pulse;

    for (genvar i = 0; i < NUM_LH; i++) begin : g_lh
        anx_lh_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .set_i (lh_set[i]),
            .clr_i (rd_hit),
            .q_o   (lh_q[i])
        );
    end

    anx_an_able u_an_able (
        .clk       (clk),
        .rst       (rst),
        .flp_i     (flp_valid_pulse),
        .restart_i (an_restart),
        .q_o       (an_able)
    );

    always_comb begin
        bits.pd_fault   = lh_q[LH_PDF];
        bits.lp_np      = partner_np;
        bits.np_able    = 1'b1;
        bits.page_rx    = lh_q[LH_PAGE];
        bits.lp_an_able = an_able;
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_q <= '0;
        else if (rd_hit) rd_q <= anx_pack(bits);
        else             rd_q <= '0;
    end

    assign rd_data = rd_q;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[REG_W-1:POS_PD_FAULT+1] == '0);                  // R8
    AST_NP_ABLE_ONE: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> rd_data[POS_NP_ABLE]);                        // R8
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |=> (rd_data == '0));                            // R2
    AST_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_hit && lh_set == '0) |=> $stable(lh_q));   // R10
endmodule

// File: tb/anx_status_reg_tb.sv
module anx_status_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        rd_en, wr_en;
    logic [4:0]  addr;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        pd_fault_pulse, page_stored_pulse, partner_np;
    logic        flp_valid_pulse, an_restart;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    anx_status_reg dut_i (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .pd_fault_pulse(pd_fault_pulse), .page_stored_pulse(page_stored_pulse),
        .partner_np(partner_np), .flp_valid_pulse(flp_valid_pulse),
        .an_restart(an_restart)
    );

    // {pd, page, np, flp, restart, write, expected word}
    localparam int NV = 12;
    localparam logic [21:0] VECS [NV] = '{
        {6'b000000, 16'h0004},  // R8 idle
        {6'b100000, 16'h0014},  // R3 fault latched
        {6'b000000, 16'h0004},  // R5 cleared by prior read
        {6'b011000, 16'h000E},  // R4 R7 page + np
        {6'b001000, 16'h000C},  // R7 np live, page cleared
        {6'b000100, 16'h0005},  // R9 burst sets bit 0
        {6'b000000, 16'h0005},  // R9 survives read
        {6'b000001, 16'h0005},  // R10 write ignored
        {6'b000010, 16'h0004},  // R9 restart clears
        {6'b110100, 16'h0017},  // R3 R4 R9 together
        {6'b000110, 16'h0004},  // R9 restart beats burst
        {6'b001001, 16'h000C}   // R10 R7 write with np
    };

    function automatic string vec_tag(int i);
        case (i)
            1:       return "R3";
            2:       return "R5";
            3, 4:    return "R7";
            5, 6, 8, 10: return "R9";
            7, 11:   return "R10";
            9:       return "R4";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle();
        rd_en = 0; wr_en = 0; addr = 5'd0; wr_data = '0;
        pd_fault_pulse = 0; page_stored_pulse = 0; flp_valid_pulse = 0;
        an_restart = 0;
    endtask

    // strobe a read at the next negedge window and sample one cycle later
    task automatic do_read(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1; addr = a;
        @(negedge clk);
        rd_en = 0; addr = 5'd0;
        v = rd_data;
    endtask

    task automatic pulse(input logic pd, input logic pg, input logic fl,
                         input logic rs, input logic wr);
        @(negedge clk);
        pd_fault_pulse = pd; page_stored_pulse = pg; flp_valid_pulse = fl;
        an_restart = rs; wr_en = wr; addr = wr ? 5'd6 : 5'd0;
        wr_data = wr ? 16'hFFFF : 16'h0;
        @(negedge clk);
        idle();
    endtask

    initial begin
        #200000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] v;
        idle();
        partner_np = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        check("R1 in reset", rd_data, 16'h0000);
        rst = 0;
        @(negedge clk);
        check("R1 after reset", rd_data, 16'h0000);
        do_read(5'd6, v);
        check("R1 first read", v, 16'h0004);

        for (int i = 0; i < NV; i++) begin
            partner_np = VECS[i][19];
            pulse(VECS[i][21], VECS[i][20], VECS[i][18], VECS[i][17], VECS[i][16]);
            do_read(5'd6, v);
            partner_np = 0;
            check(vec_tag(i), v, VECS[i][15:0]);
        end

        // R2: other address reads zero and does not clear
        pulse(1, 0, 0, 0, 0);
        do_read(5'd5, v);
        check("R2 other addr", v, 16'h0000);
        do_read(5'd6, v);
        check("R2 not cleared", v, 16'h0014);

        // R5: back-to-back reads
        pulse(0, 1, 0, 0, 0);
        do_read(5'd6, v);
        check("R5 pre-clear", v, 16'h0006);
        do_read(5'd6, v);
        check("R5 post-clear", v, 16'h0004);

        // R6: event on the same edge as the read
        @(negedge clk);
        rd_en = 1; addr = 5'd6; page_stored_pulse = 1; pd_fault_pulse = 1;
        @(negedge clk);
        idle();
        check("R6 old value", rd_data, 16'h0004);
        do_read(5'd6, v);
        check("R6 kept", v, 16'h0016);

        // R10: write to addr 6 while bits latched
        pulse(1, 0, 1, 0, 0);
        pulse(0, 0, 0, 0, 1);
        do_read(5'd6, v);
        check("R10 latched kept", v, 16'h0015);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule